// File: doc/BRIEF.md
# OUT Endpoint Receive Packet Buffer

This block holds received packets for one bulk or interrupt OUT endpoint between the bus receiver and the processor. The receiver side streams bytes into a buffer slot and marks the end of each packet. The processor side reads the byte count of the oldest packet, pops its bytes from a data port and then frees the slot. A slot is freed either by an explicit release strobe or, when automatic release is enabled, by the pop that takes the last byte of the packet.

The block runs with one slot or with two slots used in alternation. It reports its occupancy as a 2-bit code whose meaning depends on the slot mode. In continuous mode, several bus packets fill one slot and the whole slot is handed to the processor as a single unit. The block also carries three sticky error flags: overrun, forced stall and data error.

Top module: `ep_out_rxbuf`

## Requirements
- R1: After reset the occupancy code is 00, the count reads 0, the data port reads 0 and all three error flags are 0.
- R2: Occupancy code: 00 means no slot is held, in both modes. With cfg_double=0, 11 means one slot is held. With cfg_double=1, 10 means one slot is held and 11 means two. Code 01 never appears, and with cfg_double=0 code 10 never appears. The code changes in the cycle after the edge that commits or frees a slot.
- R3: cpu_cnt gives the byte count of the oldest held slot, including 0 for a zero-length packet, and reads 0 when nothing is held.
- R4: Bytes leave the data port in the order they arrived. With two slots, packets are handed out in the order they were committed.
- R5: A cpu_clr_rdy pulse while a slot is held frees the oldest slot, whether or not it has been read.
- R6: With cfg_auto_rel=1, the pop that takes the last counted byte of the oldest slot frees it without cpu_clr_rdy.
- R7: With cfg_auto_rel=0, a pop after all counted bytes have been read returns 0, does not free the slot and does not change the count.
- R8: A pop while the code is 00 returns 0 and does not move the read position: the next packet is read from its first byte.
- R9: A packet end while every slot is held sets the sticky overrun flag and discards that packet. The held data and count stay intact. A cpu_clr_ovr pulse clears the flag.
- R10: With cfg_cont=1, packet ends append to the current slot. The slot is committed only when it holds SLOT_BYTES bytes, or when the packet just ended carried fewer than MPS bytes.
- R11: The stall and data-error flags set on their input pulses and clear on their own clear pulses. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_double | input | 1 | 1: two alternating slots, 0: one slot |
| cfg_auto_rel | input | 1 | Free the slot automatically on its last pop |
| cfg_cont | input | 1 | Continuous mode: a slot collects several packets |
| usb_byte_vld | input | 1 | Received byte strobe |
| usb_byte | input | DATA_W | Received byte |
| usb_pkt_end | input | 1 | End of received packet, in a cycle with no byte |
| usb_stall_set | input | 1 | Set the forced-stall flag |
| usb_derr_set | input | 1 | Set the data-error flag |
| cpu_rd | input | 1 | Pop one byte from the data port |
| cpu_rd_data | output | DATA_W | Byte at the read position, or 0 |
| cpu_cnt | output | CNT_W | Byte count of the oldest held slot |
| cpu_clr_rdy | input | 1 | Free the oldest held slot |
| cpu_clr_ovr | input | 1 | Clear the overrun flag |
| cpu_clr_stall | input | 1 | Clear the forced-stall flag |
| cpu_clr_derr | input | 1 | Clear the data-error flag |
| occ_status | output | 2 | Occupancy code |
| ovr_flag | output | 1 | Sticky overrun |
| stall_flag | output | 1 | Sticky forced stall |
| derr_flag | output | 1 | Sticky data error |

## Verification
The bench builds the block with SLOT_BYTES=8 and MPS=4 rather than the defaults. With these values a continuous-mode slot fills after two full-size packets, so both commit triggers (full slot and short packet) can be reached in a few dozen cycles. Every count also stays small enough to list byte by byte in the vector table. Single-slot, double-slot, automatic-release and overrun sequences all run with these same values.

// File: rtl/ep_out_pkg.sv
`timescale 1ns/1ps
package ep_out_pkg;
  typedef enum logic [1:0] {
    OCC_NONE = 2'b00,
    OCC_RSVD = 2'b01,
    OCC_HALF = 2'b10,
    OCC_FULL = 2'b11
  } occ_code_t;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_OVR   = 0;
  localparam int unsigned FLG_STALL = 1;
  localparam int unsigned FLG_DERR  = 2;

  function automatic occ_code_t occ_encode(input logic dbl, input logic [1:0] n);
    occ_code_t c;
    case (n)
      2'd0:    c = OCC_NONE;
      2'd1:    c = dbl ? OCC_HALF : OCC_FULL;
      default: c = OCC_FULL;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ep_out_fill.sv
`timescale 1ns/1ps
module ep_out_fill #(
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned MPS        = 64,
  localparam int unsigned CNT_W     = $clog2(SLOT_BYTES + 1),
  localparam int unsigned IDX_W     = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int unsigned PC_W      = $clog2(MPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_double,
  input  logic             cfg_cont,
  input  logic             byte_vld,
  input  logic             pkt_end,
  input  logic             slot_free,
  output logic             mem_we,
  output logic             fill_slot,
  output logic [IDX_W-1:0] fill_idx,
  output logic             commit,
  output logic [CNT_W-1:0] commit_len,
  output logic             overrun_evt
);
  logic [CNT_W-1:0] fill_cnt_q, fill_cnt_d;
  logic [PC_W-1:0]  pkt_cnt_q,  pkt_cnt_d;
  logic             slot_q,     slot_d;
  logic             slot_full;

  assign slot_full  = (fill_cnt_q == CNT_W'(SLOT_BYTES));
  assign fill_slot  = slot_q;
  assign fill_idx   = fill_cnt_q[IDX_W-1:0];
  assign commit_len = fill_cnt_q;

  always_comb begin
    mem_we      = byte_vld && slot_free && !slot_full;
    fill_cnt_d  = fill_cnt_q;
    pkt_cnt_d   = pkt_cnt_q;
    slot_d      = slot_q;
    commit      = 1'b0;
    overrun_evt = 1'b0;
    if (mem_we) fill_cnt_d = fill_cnt_q + CNT_W'(1);
    if (byte_vld && (pkt_cnt_q != PC_W'(MPS))) pkt_cnt_d = pkt_cnt_q + PC_W'(1);
    if (pkt_end) begin
      pkt_cnt_d = '0;
      if (!slot_free) begin
        overrun_evt = 1'b1;
        fill_cnt_d  = '0;
      end else if (!cfg_cont || slot_full || (pkt_cnt_q < PC_W'(MPS))) begin
        commit     = 1'b1;
        fill_cnt_d = '0;
        slot_d     = cfg_double ? ~slot_q : 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt_q <= '0;
      pkt_cnt_q  <= '0;
      slot_q     <= 1'b0;
    end else begin
      fill_cnt_q <= fill_cnt_d;
      pkt_cnt_q  <= pkt_cnt_d;
      slot_q     <= slot_d;
    end
  end

  p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt_q <= CNT_W'(SLOT_BYTES));
  p_end_no_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_end && byte_vld));
  p_overrun_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |-> !commit);
endmodule

// File: rtl/ep_out_drain.sv
`timescale 1ns/1ps
module ep_out_drain #(
  parameter int unsigned SLOT_BYTES = 64,
  localparam int unsigned CNT_W     = $clog2(SLOT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_double,
  input  logic             cfg_auto_rel,
  input  logic             rd_req,
  input  logic             clr_req,
  input  logic             have_pkt,
  input  logic [CNT_W-1:0] head_len,
  output logic             rd_slot,
  output logic [CNT_W-1:0] rd_ptr,
  output logic             byte_avail,
  output logic             release_evt
);
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic             slot_q, slot_d;
  logic             pop, last_pop;

  assign rd_slot    = slot_q;
  assign rd_ptr     = ptr_q;
  assign byte_avail = have_pkt && (ptr_q < head_len);

  always_comb begin
    pop         = rd_req && byte_avail;
    last_pop    = pop && ((ptr_q + CNT_W'(1)) == head_len);
    release_evt = have_pkt && (clr_req || (cfg_auto_rel && last_pop));
    ptr_d       = ptr_q;
    slot_d      = slot_q;
    if (release_evt) begin
      ptr_d  = '0;
      slot_d = cfg_double ? ~slot_q : 1'b0;
    end else if (pop) begin
      ptr_d = ptr_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      slot_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      slot_q <= slot_d;
    end
  end

  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    have_pkt |-> (ptr_q <= head_len));
  p_empty_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !have_pkt |-> (ptr_q == '0));
endmodule

// File: rtl/ep_out_flags.sv
`timescale 1ns/1ps
module ep_out_flags #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);
  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_flag
      logic q, d;
      always_comb begin
        d = q;
        if (clr_i[g]) d = 1'b0;
        if (set_i[g]) d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign flag_o[g] = q;

      p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i[g]) |=> q);
      p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[g] |=> q);
    end
  endgenerate
endmodule

// File: rtl/ep_out_rxbuf.sv
`timescale 1ns/1ps
module ep_out_rxbuf
  import ep_out_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned MPS        = 64,
  localparam int unsigned CNT_W     = $clog2(SLOT_BYTES + 1),
  localparam int unsigned IDX_W     = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1,
  localparam int unsigned NSLOT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_double,
  input  logic              cfg_auto_rel,
  input  logic              cfg_cont,
  input  logic              usb_byte_vld,
  input  logic [DATA_W-1:0] usb_byte,
  input  logic              usb_pkt_end,
  input  logic              usb_stall_set,
  input  logic              usb_derr_set,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic [CNT_W-1:0]  cpu_cnt,
  input  logic              cpu_clr_rdy,
  input  logic              cpu_clr_ovr,
  input  logic              cpu_clr_stall,
  input  logic              cpu_clr_derr,
  output logic [1:0]        occ_status,
  output logic              ovr_flag,
  output logic              stall_flag,
  output logic              derr_flag
);
  logic [DATA_W-1:0] mem [NSLOT][SLOT_BYTES];
  logic [CNT_W-1:0]  len_q [NSLOT];
  logic [1:0]        occ_q, occ_d, cap;
  logic              slot_free, have_pkt;
  logic              mem_we, fill_slot, commit, overrun_evt;
  logic [IDX_W-1:0]  fill_idx;
  logic [CNT_W-1:0]  commit_len, head_len, rd_ptr;
  logic              rd_slot, byte_avail, release_evt;
  logic [NUM_FLAGS-1:0] fset, fclr, fq;

  assign cap       = cfg_double ? 2'd2 : 2'd1;
  assign slot_free = (occ_q < cap);
  assign have_pkt  = (occ_q != 2'd0);
  assign head_len  = len_q[rd_slot];

  ep_out_fill #(.SLOT_BYTES(SLOT_BYTES), .MPS(MPS)) u_fill (
    .clk(clk), .rst_n(rst_n), .cfg_double(cfg_double), .cfg_cont(cfg_cont),
    .byte_vld(usb_byte_vld), .pkt_end(usb_pkt_end), .slot_free(slot_free),
    .mem_we(mem_we), .fill_slot(fill_slot), .fill_idx(fill_idx),
    .commit(commit), .commit_len(commit_len), .overrun_evt(overrun_evt)
  );

  ep_out_drain #(.SLOT_BYTES(SLOT_BYTES)) u_drain (
    .clk(clk), .rst_n(rst_n), .cfg_double(cfg_double), .cfg_auto_rel(cfg_auto_rel),
    .rd_req(cpu_rd), .clr_req(cpu_clr_rdy), .have_pkt(have_pkt), .head_len(head_len),
    .rd_slot(rd_slot), .rd_ptr(rd_ptr), .byte_avail(byte_avail),
    .release_evt(release_evt)
  );

  assign fset[FLG_OVR]   = overrun_evt;
  assign fset[FLG_STALL] = usb_stall_set;
  assign fset[FLG_DERR]  = usb_derr_set;
  assign fclr[FLG_OVR]   = cpu_clr_ovr;
  assign fclr[FLG_STALL] = cpu_clr_stall;
  assign fclr[FLG_DERR]  = cpu_clr_derr;

  ep_out_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(fset), .clr_i(fclr), .flag_o(fq)
  );

  assign ovr_flag   = fq[FLG_OVR];
  assign stall_flag = fq[FLG_STALL];
  assign derr_flag  = fq[FLG_DERR];

  always_ff @(posedge clk) begin
    if (mem_we) mem[fill_slot][fill_idx] <= usb_byte;
  end

  always_comb begin
    occ_d = occ_q;
    if (commit && !release_evt)      occ_d = occ_q + 2'd1;
    else if (release_evt && !commit) occ_d = occ_q - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 2'd0;
      for (int i = 0; i < NSLOT; i++) len_q[i] <= '0;
    end else begin
      occ_q <= occ_d;
      if (commit) len_q[fill_slot] <= commit_len;
    end
  end

  assign cpu_rd_data = byte_avail ? mem[rd_slot][rd_ptr[IDX_W-1:0]] : '0;
  assign cpu_cnt     = have_pkt ? head_len : '0;
  assign occ_status  = occ_encode(cfg_double, occ_q);

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_status != 2'b01);
  p_single_no_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_double |-> (occ_status != 2'b10));
  p_capacity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= cap);
  p_empty_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_status == 2'b00) |-> (cpu_cnt == '0 && cpu_rd_data == '0));
  p_release_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && !commit) |=> (occ_q == $past(occ_q) - 2'd1));
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !release_evt) |=> $stable(occ_q));
endmodule

// File: tb/ep_out_rxbuf_test.sv
`timescale 1ns/1ps
module ep_out_rxbuf_test;
  localparam int DW = 8;
  localparam int SB = 8;
  localparam int MP = 4;
  localparam int CW = $clog2(SB + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_double, cfg_auto_rel, cfg_cont;
  logic usb_byte_vld, usb_pkt_end, usb_stall_set, usb_derr_set;
  logic [DW-1:0] usb_byte;
  logic cpu_rd, cpu_clr_rdy, cpu_clr_ovr, cpu_clr_stall, cpu_clr_derr;
  logic [DW-1:0] cpu_rd_data;
  logic [CW-1:0] cpu_cnt;
  logic [1:0] occ_status;
  logic ovr_flag, stall_flag, derr_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ep_out_rxbuf #(.DATA_W(DW), .SLOT_BYTES(SB), .MPS(MP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_double(cfg_double), .cfg_auto_rel(cfg_auto_rel),
    .cfg_cont(cfg_cont), .usb_byte_vld(usb_byte_vld), .usb_byte(usb_byte),
    .usb_pkt_end(usb_pkt_end), .usb_stall_set(usb_stall_set), .usb_derr_set(usb_derr_set),
    .cpu_rd(cpu_rd), .cpu_rd_data(cpu_rd_data), .cpu_cnt(cpu_cnt),
    .cpu_clr_rdy(cpu_clr_rdy), .cpu_clr_ovr(cpu_clr_ovr), .cpu_clr_stall(cpu_clr_stall),
    .cpu_clr_derr(cpu_clr_derr), .occ_status(occ_status), .ovr_flag(ovr_flag),
    .stall_flag(stall_flag), .derr_flag(derr_flag)
  );

  typedef struct packed {
    logic       drain;
    logic [3:0] len;
    logic [7:0] base;
    logic [1:0] code;
    logic [3:0] cnt;
  } vec_t;

  // double-slot sequence, manual release
  localparam vec_t VECS [8] = '{
    '{1'b0, 4'd3, 8'h10, 2'b10, 4'd3},
    '{1'b0, 4'd5, 8'h20, 2'b11, 4'd3},
    '{1'b1, 4'd3, 8'h10, 2'b10, 4'd5},
    '{1'b0, 4'd0, 8'h00, 2'b11, 4'd5},
    '{1'b1, 4'd5, 8'h20, 2'b10, 4'd0},
    '{1'b1, 4'd0, 8'h00, 2'b00, 4'd0},
    '{1'b0, 4'd8, 8'h40, 2'b10, 4'd8},
    '{1'b1, 4'd8, 8'h40, 2'b00, 4'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic dbl, input logic aut, input logic cont);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_double = dbl; cfg_auto_rel = aut; cfg_cont = cont;
    usb_byte_vld = 0; usb_byte = '0; usb_pkt_end = 0; usb_stall_set = 0; usb_derr_set = 0;
    cpu_rd = 0; cpu_clr_rdy = 0; cpu_clr_ovr = 0; cpu_clr_stall = 0; cpu_clr_derr = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_pkt(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      usb_byte_vld = 1'b1;
      usb_byte = DW'(base + i);
      @(negedge clk);
    end
    usb_byte_vld = 1'b0;
    usb_pkt_end = 1'b1;
    @(negedge clk);
    usb_pkt_end = 1'b0;
  endtask

  task automatic pop_byte(output int val);
    val = int'(cpu_rd_data);
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic pulse_clr;
    cpu_clr_rdy = 1'b1;
    @(negedge clk);
    cpu_clr_rdy = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0;
    // R1 reset state
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R1", "code", occ_status, 0);
    chk("R1", "cnt", cpu_cnt, 0);
    chk("R1", "data", cpu_rd_data, 0);
    chk("R1", "flags", {ovr_flag, stall_flag, derr_flag}, 0);

    // R2 R3 R4 R5 vector walk, two slots
    foreach (VECS[k]) begin
      if (VECS[k].drain) begin
        for (int i = 0; i < int'(VECS[k].len); i++) begin
          pop_byte(v);
          chk("R4", "byte", v, int'(VECS[k].base) + i);
        end
        pulse_clr();
      end else begin
        send_pkt(int'(VECS[k].len), int'(VECS[k].base));
      end
      chk("R2", "code", occ_status, int'(VECS[k].code));
      chk("R3", "cnt", cpu_cnt, int'(VECS[k].cnt));
    end

    // R9 overrun in single-slot mode
    do_reset(1'b0, 1'b0, 1'b0);
    send_pkt(2, 'hE0);
    chk("R2", "single code", occ_status, 3);
    send_pkt(3, 'hF0);
    chk("R9", "ovr set", ovr_flag, 1);
    chk("R9", "code kept", occ_status, 3);
    chk("R9", "cnt kept", cpu_cnt, 2);
    chk("R9", "data kept", cpu_rd_data, 'hE0);
    repeat (3) @(negedge clk);
    chk("R9", "ovr sticky", ovr_flag, 1);
    cpu_clr_ovr = 1'b1; @(negedge clk); cpu_clr_ovr = 1'b0;
    chk("R9", "ovr clr", ovr_flag, 0);
    pulse_clr();
    chk("R5", "unread release", occ_status, 0);

    // R7 pop past count with auto release off
    send_pkt(2, 'hC0);
    pop_byte(v); pop_byte(v);
    chk("R7", "last byte", v, 'hC1);
    pop_byte(v);
    chk("R7", "past data", v, 0);
    chk("R7", "still held", occ_status, 3);
    chk("R7", "cnt same", cpu_cnt, 2);
    pulse_clr();

    // R8 pop while empty
    pop_byte(v);
    chk("R8", "empty data", v, 0);
    send_pkt(1, 'hD0);
    pop_byte(v);
    chk("R8", "first byte", v, 'hD0);

    // R6 auto release, two slots
    do_reset(1'b1, 1'b1, 1'b0);
    send_pkt(2, 'hA0);
    send_pkt(3, 'hB0);
    pop_byte(v);
    chk("R6", "mid pkt held", occ_status, 3);
    pop_byte(v);
    chk("R6", "auto freed", occ_status, 2);
    chk("R6", "next cnt", cpu_cnt, 3);
    chk("R6", "next data", cpu_rd_data, 'hB0);

    // R10 continuous mode, single slot
    do_reset(1'b0, 1'b0, 1'b1);
    send_pkt(4, 'h50);
    chk("R10", "full pkt no commit", occ_status, 0);
    send_pkt(2, 'h60);
    chk("R10", "short commit", occ_status, 3);
    chk("R10", "short cnt", cpu_cnt, 6);
    for (int i = 0; i < 6; i++) begin
      pop_byte(v);
      chk("R10", "cont byte", v, (i < 4) ? ('h50 + i) : ('h60 + i - 4));
    end
    pulse_clr();
    send_pkt(4, 'h70);
    chk("R10", "half slot", occ_status, 0);
    send_pkt(4, 'h78);
    chk("R10", "full slot commit", occ_status, 3);
    chk("R10", "full cnt", cpu_cnt, 8);

    // R11 stall and data-error flags
    usb_stall_set = 1'b1; @(negedge clk); usb_stall_set = 1'b0;
    usb_derr_set = 1'b1; @(negedge clk); usb_derr_set = 1'b0;
    chk("R11", "stall set", stall_flag, 1);
    chk("R11", "derr set", derr_flag, 1);
    cpu_clr_stall = 1'b1; @(negedge clk); cpu_clr_stall = 1'b0;
    chk("R11", "stall clr", stall_flag, 0);
    chk("R11", "derr kept", derr_flag, 1);
    usb_derr_set = 1'b1; cpu_clr_derr = 1'b1; @(negedge clk);
    usb_derr_set = 1'b0; cpu_clr_derr = 1'b0;
    chk("R11", "set wins", derr_flag, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule